// File: doc/BRIEF.md
# Raster Video Timing Generator

This block produces the scan timing for a progressive raster display at 640 by 480 pixels. It runs from a 25 MHz pixel clock, so each clock is one pixel time of 40 ns. A line lasts 32 us and a frame lasts about 16.7 ms, which is a refresh rate near 60 Hz. A column counter steps once per clock. A row counter steps once per line. The block decodes active-low horizontal and vertical sync strobes and a display-enable from the two counters. Scanning starts at the top-left pixel (row 0, column 0), moves left to right along a row, then moves down row by row.

For every visible position the block computes the word address `row*H_VIS + col` into an external pixel refresh memory. That memory returns a 3-bit colour one clock after it is addressed. The sync strobes and the display-enable pass through one register stage, so they line up with the returned colour. Colour is forced to zero whenever the aligned display-enable is low.

The default parameters give an 800-clock line: 640 visible, then 16 front porch, 96 sync, 48 back porch. They give a 521-line frame: 480 visible, then 10 front porch, 2 sync, 29 back porch. Every interval is a parameter, so the same block can run other geometries.

Top module: `raster_timing_gen`

## Requirements
- R1: The column counter runs from 0 to H_VIS+H_FP+H_SYNC+H_BP-1 and then returns to 0. It steps once per clock. A line is therefore exactly H_VIS+H_FP+H_SYNC+H_BP clocks long (800 by default).
- R2: `hsync_n` is 0 exactly when, one clock earlier, the column was in the range H_VIS+H_FP to H_VIS+H_FP+H_SYNC-1. Otherwise it is 1.
- R3: The row counter steps only in the clock where the column returns from its last value to 0. It runs from 0 to V_VIS+V_FP+V_SYNC+V_BP-1 (520 by default) and then returns to 0. `vsync_n` is 0 exactly when, one clock earlier, the row was in the range V_VIS+V_FP to V_VIS+V_FP+V_SYNC-1.
- R4: `video_en` is 1 exactly when, one clock earlier, the column was below H_VIS and the row was below V_VIS.
- R5: `fb_addr` equals row*H_VIS+col of the current counters while the position is visible, and 0 while it is not.
- R6: `pix_rgb` equals the 3-bit `fb_rdata` when `video_en` is 1, and is 0 when `video_en` is 0.
- R7: While `rst_n` is 0, both counters are 0, `hsync_n` and `vsync_n` are 1, `video_en` is 0 and `pix_rgb` is 0. Asserting `rst_n` takes effect at once, without waiting for a clock. The first clock after release delivers pixel (0,0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously |
| fb_addr | output | 19 | Refresh memory word address (default width) |
| fb_rdata | input | 3 | Colour word returned by the memory one clock after addressing |
| hsync_n | output | 1 | Horizontal sync, active low, aligned with colour |
| vsync_n | output | 1 | Vertical sync, active low, aligned with colour |
| video_en | output | 1 | Visible-region flag, aligned with colour |
| pix_rgb | output | 3 | Colour output, zero while blanked |

## Verification
Two events fall in the same clock at the end of every frame. The column wraps from its last value, and that same wrap carries the row from its last line back to 0. The vertical sync lines also overlap the horizontal sync pulses.

The bench uses a shrunken geometry so that several full frames fit in a short run. It compares all outputs every clock against a behavioural scan model. Any error in the line-end row step, in the frame wrap, or in the place where the two sync strobes overlap shows up as a miscompare in the first clock after that boundary. A mid-frame reset is also applied. It checks that the model and the design restart together at pixel (0,0).

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int PIX_W = 3;
  typedef logic [PIX_W-1:0] pix_t;
endpackage

// File: rtl/rt_axis_counter.sv
module rt_axis_counter #(
  parameter int VIS  = 640,
  parameter int FP   = 16,
  parameter int SYNC = 96,
  parameter int BP   = 48,
  localparam int TOTAL = VIS + FP + SYNC + BP,
  localparam int W     = $clog2(TOTAL)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] cnt,
  output logic         last,
  output logic         visible,
  output logic         in_sync
);
  localparam logic [W-1:0] LAST_V  = W'(TOTAL - 1);
  localparam logic [W-1:0] SYNC_LO = W'(VIS + FP);
  localparam logic [W-1:0] SYNC_HI = W'(VIS + FP + SYNC);
  localparam logic [W-1:0] VIS_V   = W'(VIS);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (adv) begin
      if (cnt_q == LAST_V) cnt_d = '0;
      else                 cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt     = cnt_q;
  assign last    = (cnt_q == LAST_V);
  assign visible = (cnt_q < VIS_V);
  assign in_sync = (cnt_q >= SYNC_LO) && (cnt_q < SYNC_HI);

  // R1: counter never leaves its range
  a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_V);
  // R1: a step from the last value returns to zero
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt_q == LAST_V) |=> (cnt_q == '0));
endmodule

// File: rtl/rt_fetch_align.sv
module rt_fetch_align
  import raster_pkg::*;
#(
  parameter int HW = 10,
  parameter int VW = 10,
  parameter int H_VIS = 640,
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] col,
  input  logic [VW-1:0] row,
  input  logic          h_vis,
  input  logic          v_vis,
  input  logic          h_sync,
  input  logic          v_sync,
  input  pix_t          rdata,
  output logic [AW-1:0] addr,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          den,
  output pix_t          rgb
);
  logic vis_now;
  logic hs_q, vs_q, de_q;
  logic hs_d, vs_d, de_d;

  assign vis_now = h_vis && v_vis;

  always_comb begin
    addr = '0;
    if (vis_now) addr = AW'(row) * AW'(H_VIS) + AW'(col);
  end

  always_comb begin
    hs_d = !h_sync;
    vs_d = !v_sync;
    de_d = vis_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b1;
      vs_q <= 1'b1;
      de_q <= 1'b0;
    end else begin
      hs_q <= hs_d;
      vs_q <= vs_d;
      de_q <= de_d;
    end
  end

  assign hsync_n = hs_q;
  assign vsync_n = vs_q;
  assign den     = de_q;
  assign rgb     = de_q ? rdata : '0;

  // R5: consecutive visible pixels of one row use consecutive words
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (vis_now && col != '0) |-> (addr == $past(addr) + 1'b1));
  // R2: horizontal sync only ever appears while blanked
  a_r2_hs_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_q |-> !de_q);
  // R3: vertical sync only ever appears while blanked
  a_r3_vs_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_q |-> !de_q);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 29,
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HW    = $clog2(H_TOT),
  localparam int VW    = $clog2(V_TOT),
  localparam int AW    = $clog2(H_VIS * V_VIS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] fb_addr,
  input  logic [2:0]    fb_rdata,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          video_en,
  output logic [2:0]    pix_rgb
);
  logic [HW-1:0] col;
  logic [VW-1:0] row;
  logic h_last, h_vis, h_sync;
  logic v_last, v_vis, v_sync;
  pix_t rgb_w;

  rt_axis_counter #(.VIS(H_VIS), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP)) u_col (
    .clk(clk), .rst_n(rst_n), .adv(1'b1), .cnt(col), .last(h_last),
    .visible(h_vis), .in_sync(h_sync));

  rt_axis_counter #(.VIS(V_VIS), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP)) u_row (
    .clk(clk), .rst_n(rst_n), .adv(h_last), .cnt(row), .last(v_last),
    .visible(v_vis), .in_sync(v_sync));

  rt_fetch_align #(.HW(HW), .VW(VW), .H_VIS(H_VIS), .AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .col(col), .row(row), .h_vis(h_vis),
    .v_vis(v_vis), .h_sync(h_sync), .v_sync(v_sync), .rdata(pix_t'(fb_rdata)),
    .addr(fb_addr), .hsync_n(hsync_n), .vsync_n(vsync_n), .den(video_en),
    .rgb(rgb_w));

  assign pix_rgb = rgb_w;

  // R3: the row moves only on the clock after the column's last value
  a_r3_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (row != $past(row)) |-> ($past(col) == HW'(H_TOT - 1)));
  // R3: frame wrap coincides with a line wrap
  a_r3_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (h_last && v_last) |=> (row == '0 && col == '0));
  // R6: colour is dark whenever the aligned enable is low
  a_r6_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !video_en |-> (pix_rgb == 3'd0));
endmodule

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;
  localparam int HV = 8, HF = 2, HS = 3, HB = 2;
  localparam int VV = 4, VF = 1, VS = 2, VB = 3;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int AW = $clog2(HV * VV);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] fb_addr;
  logic [2:0] fb_rdata;
  logic hsync_n, vsync_n, video_en;
  logic [2:0] pix_rgb;
  logic [2:0] mem [0:HV*VV-1];

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  int cc = 0, cr = 0;
  int pc = 0, pr = 0;
  bit prst = 1'b1;

  always #4 clk = ~clk;

  raster_timing_gen #(.H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
                      .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)) uut (
    .clk(clk), .rst_n(rst_n), .fb_addr(fb_addr), .fb_rdata(fb_rdata),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .video_en(video_en), .pix_rgb(pix_rgb));

  always_ff @(posedge clk) fb_rdata <= mem[fb_addr];

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (row %0d col %0d)", req, act, exp, cr, cc);
    end
  endtask

  task automatic compare_all();
    int e_hs, e_vs, e_de, e_rgb, e_addr;
    if (prst) begin
      e_hs = 1; e_vs = 1; e_de = 0; e_rgb = 0;       // R7 reset state
    end else begin
      e_hs = (pc >= HV + HF && pc < HV + HF + HS) ? 0 : 1;
      e_vs = (pr >= VV + VF && pr < VV + VF + VS) ? 0 : 1;
      e_de = (pc < HV && pr < VV) ? 1 : 0;
      e_rgb = e_de ? int'(mem[pr * HV + pc]) : 0;
    end
    e_addr = (cc < HV && cr < VV) ? cr * HV + cc : 0;
    chk(prst ? "R7 hsync_n" : "R2 hsync_n (R1 line length)", int'(hsync_n), e_hs);
    chk(prst ? "R7 vsync_n" : "R3 vsync_n", int'(vsync_n), e_vs);
    chk(prst ? "R7 video_en" : "R4 video_en", int'(video_en), e_de);
    chk(prst ? "R7 pix_rgb" : "R6 pix_rgb", int'(pix_rgb), e_rgb);
    chk("R5 fb_addr", int'(fb_addr), e_addr);
  endtask

  task automatic cycle(input bit run);
    @(negedge clk);
    compare_all();
    rst_n = run;
    if (run) begin
      pc = cc; pr = cr; prst = 1'b0;
      if (cc == HT - 1) begin
        cc = 0;
        cr = (cr == VT - 1) ? 0 : cr + 1;
      end else begin
        cc = cc + 1;
      end
    end else begin
      cc = 0; cr = 0; prst = 1'b1;
    end
  endtask

  initial begin
    for (int i = 0; i < HV * VV; i++) mem[i] = 3'((i * 5 + 3) % 8);
    for (int i = 0; i < 3; i++) cycle(1'b0);
    // several frames: frame wrap coincides with line wrap (R3)
    for (int i = 0; i < 2 * HT * VT + 37; i++) cycle(1'b1);
    // mid-frame reset, then restart from pixel (0,0) (R7)
    for (int i = 0; i < 2; i++) cycle(1'b0);
    for (int i = 0; i < 2 * HT * VT + 5; i++) cycle(1'b1);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule